// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator, split into a high word and a low word, and adds a signed product to it once per accepted operation. Each operation carries two 32-bit operands, a mode select and a saturation enable. Long mode multiplies the two full operands as signed 32-bit numbers. Word mode multiplies only the sign-extended low 16 bits of each operand.

With saturation enabled, the two modes clamp the sum in different ways. Long mode limits the high word to a 48-bit style range: the upper sixteen bits of the high word follow the sign of the sum, and a non-negative sum keeps only the low fifteen bits of the high word. Word mode clamps the sum to the signed 32-bit range. When that clamp acts, the high word is set to 1 as an overflow marker.

A synchronous clear and separate direct-load ports for each half let the surrounding logic set the accumulator before a run or between runs. Both halves are visible on the outputs at all times. The unit accepts one operation in every cycle.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset both accumulator halves read zero, and `in_ready` is 1 in every cycle, during and after reset.
- R2: With `op_word`=0 (long mode) and `sat_en`=0, an accepted operation replaces {acc_hi, acc_lo} with the 64-bit wrap-around sum of the accumulator and the signed 32x32 product of `op_a` and `op_b`.
- R3: With `op_word`=1 (word mode), bits 15:0 of each operand are sign-extended and multiplied, and bits 31:16 are ignored. When `sat_en`=0, or when the sum lies within the signed 32-bit range, the whole 64-bit sum is written to both halves.
- R4: In long mode with `sat_en`=1, `acc_lo` takes bits 31:0 of the sum. If the 64-bit sum is negative, `acc_hi` is sum bits 63:32 with bits 31:16 forced to 1. Otherwise `acc_hi` is sum bits 46:32 with bits 31:15 cleared.
- R5: In word mode with `sat_en`=1, a sum below -2^31 writes `acc_hi`=1 and `acc_lo`=0x80000000.
- R6: In word mode with `sat_en`=1, a sum above 2^31-1 writes `acc_hi`=1 and `acc_lo`=0x7FFFFFFF.
- R7: `clr`=1 zeroes both halves on the next edge. It takes precedence over the load ports and over any operation in the same cycle.
- R8: `ld_hi_en` and `ld_lo_en` each load their own half from `ld_hi_val` or `ld_lo_val` on the next edge, and a half that is not loaded keeps its value. If either load enable is set, an operation offered in the same cycle is dropped.
- R9: The result of an operation accepted at a clock edge appears on `acc_hi`/`acc_lo` right after that edge. In a cycle with no clear, no load and `in_valid`=0, the accumulator does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_ready | output | 1 | Unit can take an operation (always 1) |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| op_word | input | 1 | 0 = long 32x32 mode, 1 = word 16x16 mode |
| sat_en | input | 1 | Enables mode-specific saturation |
| clr | input | 1 | Synchronous clear of both halves |
| ld_hi_en | input | 1 | Load the high word |
| ld_hi_val | input | 32 | Value for the high-word load |
| ld_lo_en | input | 1 | Load the low word |
| ld_lo_val | input | 32 | Value for the low-word load |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
The hardest case to reach from the ports is word-mode saturation. One word product is at most 2^30 in magnitude, so a run that starts from zero needs several operations to cross the 32-bit limit. The bench uses the load ports to set the accumulator just inside the signed 32-bit limit on either side, and then applies a single word product to push the sum past it. The same preload, repeated with saturation disabled, shows the unclamped carry into the high word. Arbitrary preloads of the high word also set up the long-mode clamp for both signs.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic {
      MODE_LONG = 1'b0,
      MODE_WORD = 1'b1
   } mac_mode_e;
endpackage

// File: rtl/mac_prod.sv
module mac_prod #(
   parameter int WORD_W  = 32,
   parameter int SHORT_W = 16,
   parameter int VARIANT = 0
) (
   input  logic [WORD_W-1:0]   a,
   input  logic [WORD_W-1:0]   b,
   input  mac_pkg::mac_mode_e  mode,
   output logic [2*WORD_W-1:0] prod
);
   localparam int PW = 2 * WORD_W;

   if (SHORT_W < 2 || SHORT_W > WORD_W) begin : g_bad_short
      $error("mac_prod: SHORT_W must lie in 2..WORD_W");
   end
   if (VARIANT != 0 && VARIANT != 1) begin : g_bad_var
      $error("mac_prod: VARIANT must be 0 or 1");
   end

   logic [PW-1:0] a_long, b_long, a_short, b_short;

   assign a_long  = {{WORD_W{a[WORD_W-1]}}, a};
   assign b_long  = {{WORD_W{b[WORD_W-1]}}, b};
   assign a_short = {{(PW-SHORT_W){a[SHORT_W-1]}}, a[SHORT_W-1:0]};
   assign b_short = {{(PW-SHORT_W){b[SHORT_W-1]}}, b[SHORT_W-1:0]};

   if (VARIANT == 0) begin : g_shared
      logic [PW-1:0] mx_a, mx_b;
      assign mx_a = (mode == mac_pkg::MODE_WORD) ? a_short : a_long;
      assign mx_b = (mode == mac_pkg::MODE_WORD) ? b_short : b_long;
      assign prod = mx_a * mx_b;
   end else begin : g_split
      logic [PW-1:0] p_long, p_short;
      assign p_long  = a_long * b_long;
      assign p_short = a_short * b_short;
      assign prod    = (mode == mac_pkg::MODE_WORD) ? p_short : p_long;
   end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
   parameter int WORD_W    = 32,
   parameter int LONG_ONES = 16
) (
   input  logic [2*WORD_W-1:0] sum,
   input  mac_pkg::mac_mode_e  mode,
   input  logic                sat_en,
   output logic [WORD_W-1:0]   hi_n,
   output logic [WORD_W-1:0]   lo_n
);
   localparam int PW        = 2 * WORD_W;
   localparam int LONG_KEEP = WORD_W - LONG_ONES - 1;

   if (LONG_ONES < 1 || LONG_KEEP < 1) begin : g_bad_ones
      $error("mac_sat: LONG_ONES must leave at least one kept bit");
   end

   logic [WORD_W-1:0] raw_hi, raw_lo;
   logic [WORD_W-1:0] force_mask, keep_mask;
   logic [WORD_W:0]   top_bits;
   logic              neg, fits_word;
   logic [WORD_W-1:0] pos_limit, neg_limit;

   assign raw_hi     = sum[PW-1:WORD_W];
   assign raw_lo     = sum[WORD_W-1:0];
   assign neg        = sum[PW-1];
   assign force_mask = {{LONG_ONES{1'b1}}, {(WORD_W-LONG_ONES){1'b0}}};
   assign keep_mask  = {{(WORD_W-LONG_KEEP){1'b0}}, {LONG_KEEP{1'b1}}};
   assign top_bits   = sum[PW-1:WORD_W-1];
   assign fits_word  = (&top_bits) | ~(|top_bits);
   assign pos_limit  = {1'b0, {(WORD_W-1){1'b1}}};
   assign neg_limit  = {1'b1, {(WORD_W-1){1'b0}}};

   always_comb begin
      hi_n = raw_hi;
      lo_n = raw_lo;
      if (sat_en) begin
         if (mode == mac_pkg::MODE_LONG) begin
            hi_n = neg ? (raw_hi | force_mask) : (raw_hi & keep_mask);
         end else if (!fits_word) begin
            hi_n = {{(WORD_W-1){1'b0}}, 1'b1};
            lo_n = neg ? neg_limit : pos_limit;
         end
      end
   end
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld_hi_en,
   input  logic [WORD_W-1:0] ld_hi_val,
   input  logic              ld_lo_en,
   input  logic [WORD_W-1:0] ld_lo_val,
   input  logic              upd_en,
   input  logic [WORD_W-1:0] upd_hi,
   input  logic [WORD_W-1:0] upd_lo,
   output logic [WORD_W-1:0] acc_hi,
   output logic [WORD_W-1:0] acc_lo
);
   logic any_ld;
   assign any_ld = ld_hi_en | ld_lo_en;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_hi <= '0;
         acc_lo <= '0;
      end else if (any_ld) begin
         if (ld_hi_en) acc_hi <= ld_hi_val;
         if (ld_lo_en) acc_lo <= ld_lo_val;
      end else if (upd_en) begin
         acc_hi <= upd_hi;
         acc_lo <= upd_lo;
      end
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_hi == '0 && acc_lo == '0)); // R7
   AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld_hi_en) |=> acc_hi == $past(ld_hi_val)); // R8
   AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld_lo_en) |=> acc_lo == $past(ld_lo_val)); // R8
   AST_LOAD_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld_hi_en && !ld_lo_en) |=> $stable(acc_lo)); // R8
   AST_LOAD_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld_lo_en && !ld_hi_en) |=> $stable(acc_hi)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !any_ld && !upd_en) |=> ($stable(acc_hi) && $stable(acc_lo))); // R9
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
   parameter int WORD_W    = 32,
   parameter int SHORT_W   = 16,
   parameter int LONG_ONES = 16,
   parameter int VARIANT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic              op_word,
   input  logic              sat_en,
   input  logic              clr,
   input  logic              ld_hi_en,
   input  logic [WORD_W-1:0] ld_hi_val,
   input  logic              ld_lo_en,
   input  logic [WORD_W-1:0] ld_lo_val,
   output logic [WORD_W-1:0] acc_hi,
   output logic [WORD_W-1:0] acc_lo
);
   localparam int PW = 2 * WORD_W;

   if (WORD_W < 4) begin : g_bad_word
      $error("mac_sat_unit: WORD_W too small");
   end

   mac_pkg::mac_mode_e mode;
   logic [PW-1:0]      prod, sum;
   logic [WORD_W-1:0]  nxt_hi, nxt_lo;
   logic               take;

   assign in_ready = 1'b1;
   assign mode     = op_word ? mac_pkg::MODE_WORD : mac_pkg::MODE_LONG;
   assign sum      = {acc_hi, acc_lo} + prod;
   assign take     = in_valid & in_ready;

   mac_prod #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .VARIANT(VARIANT)) u_prod (
      .a(op_a), .b(op_b), .mode(mode), .prod(prod)
   );

   mac_sat #(.WORD_W(WORD_W), .LONG_ONES(LONG_ONES)) u_sat (
      .sum(sum), .mode(mode), .sat_en(sat_en), .hi_n(nxt_hi), .lo_n(nxt_lo)
   );

   mac_acc_reg #(.WORD_W(WORD_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ld_hi_en(ld_hi_en), .ld_hi_val(ld_hi_val),
      .ld_lo_en(ld_lo_en), .ld_lo_val(ld_lo_val),
      .upd_en(take), .upd_hi(nxt_hi), .upd_lo(nxt_lo),
      .acc_hi(acc_hi), .acc_lo(acc_lo)
   );

   logic plain_op;
   assign plain_op = take & ~clr & ~ld_hi_en & ~ld_lo_en;

   AST_LONG_SAT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_op && !op_word && sat_en) |=>
         ((&acc_hi[WORD_W-1:WORD_W-LONG_ONES]) ||
          (acc_hi[WORD_W-1:WORD_W-LONG_ONES-1] == '0))); // R4
   AST_WORD_SAT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_op && op_word && sat_en) |=>
         ((acc_hi == '0 && !acc_lo[WORD_W-1]) ||
          (&acc_hi && acc_lo[WORD_W-1]) ||
          (acc_hi == WORD_W'(1) &&
           (acc_lo == {1'b1, {(WORD_W-1){1'b0}}} ||
            acc_lo == {1'b0, {(WORD_W-1){1'b1}}})))); // R5
   AST_ALWAYS_READY: assert property (@(posedge clk)
      $past(in_valid) |-> in_ready); // R1
endmodule

// File: tb/mac_sat_unit_test.sv
module mac_sat_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   typedef struct {
      logic [31:0] hi;
      logic [31:0] lo;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0, clr = 1'b0;
   logic        ld_hi_en = 1'b0, ld_lo_en = 1'b0;
   logic [31:0] op_a = '0, op_b = '0, ld_hi_val = '0, ld_lo_val = '0;
   logic        in_ready;
   logic [31:0] acc_hi, acc_lo;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   exp_t sb[$];
   logic [63:0] m_acc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_sat_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op_a(op_a), .op_b(op_b), .op_word(op_word), .sat_en(sat_en),
      .clr(clr), .ld_hi_en(ld_hi_en), .ld_hi_val(ld_hi_val),
      .ld_lo_en(ld_lo_en), .ld_lo_val(ld_lo_val),
      .acc_hi(acc_hi), .acc_lo(acc_lo)
   );

   function automatic logic [63:0] model_op(logic [63:0] acc, logic [31:0] a,
                                            logic [31:0] b, logic w, logic s);
      longint p, sm;
      logic [31:0] h;
      if (w) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
      else   p = longint'($signed(a)) * longint'($signed(b));
      sm = longint'(acc) + p;
      if (s && !w) begin
         h = sm[63:32];
         if (sm < 0) h = h | 32'hFFFF_0000;
         else        h = h & 32'h0000_7FFF;
         return {h, sm[31:0]};
      end
      if (s && w) begin
         if (sm < -longint'(64'h8000_0000)) return {32'd1, 32'h8000_0000};
         if (sm > longint'(64'h7FFF_FFFF))  return {32'd1, 32'h7FFF_FFFF};
      end
      return sm;
   endfunction

   task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic w, input logic s, input logic c,
                        input logic lh, input logic [31:0] hv,
                        input logic ll, input logic [31:0] lv, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = v; op_a = a; op_b = b; op_word = w; sat_en = s; clr = c;
      ld_hi_en = lh; ld_hi_val = hv; ld_lo_en = ll; ld_lo_val = lv;
      if (c)              m_acc = '0;
      else if (lh || ll) begin
         if (lh) m_acc[63:32] = hv;
         if (ll) m_acc[31:0]  = lv;
      end else if (v)     m_acc = model_op(m_acc, a, b, w, s);
      e.hi = m_acc[63:32]; e.lo = m_acc[31:0]; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic op(input logic [31:0] a, input logic [31:0] b, input logic w,
                     input logic s, input string tag);
      drive(1'b1, a, b, w, s, 1'b0, 1'b0, '0, 1'b0, '0, tag);
   endtask

   task automatic load(input logic [31:0] hv, input logic [31:0] lv, input string tag);
      drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, hv, 1'b1, lv, tag);
   endtask

   // monitor: samples 2 time units after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (acc_hi !== e.hi || acc_lo !== e.lo || in_ready !== 1'b1) begin
               errors++;
               $display("FAIL %s: got hi=%h lo=%h rdy=%b, expected hi=%h lo=%h rdy=1",
                        e.tag, acc_hi, acc_lo, in_ready, e.hi, e.lo);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1: got in_ready=%b during reset, expected 1", in_ready);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (acc_hi !== '0 || acc_lo !== '0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1: got hi=%h lo=%h rdy=%b, expected 0 0 1", acc_hi, acc_lo, in_ready);
      end

      // long mode, no saturation
      op(32'd3, 32'hFFFF_FFFB, 1'b0, 1'b0, "R2 3*-5");
      op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, "R2 max*max");
      op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R2 min*min");
      // clear beats load and op
      drive(1'b1, 32'd9, 32'd9, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_5678,
            1'b1, 32'h9ABC_DEF0, "R7 clear priority");
      // word mode ignores upper bits
      op(32'hABCD_8000, 32'h1234_0003, 1'b1, 1'b0, "R3 word -32768*3");
      op(32'hFFFF_0100, 32'h5555_0200, 1'b1, 1'b1, "R3 word sat in range");
      // load wins over an offered op
      drive(1'b1, 32'd100, 32'd100, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0,
            1'b1, 32'h7FFF_FF00, "R8 load beats op");
      op(32'h0000_0100, 32'h0000_0100, 1'b1, 1'b1, "R6 word sat high");
      load(32'hFFFF_FFFF, 32'h8000_0100, "R8 load negative");
      op(32'h0000_0100, 32'h0000_FF00, 1'b1, 1'b1, "R5 word sat low");
      load(32'd0, 32'h7FFF_FFFF, "R8 load edge");
      op(32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, "R3 word no sat carry");
      load(32'hFFFF_FFFF, 32'h8000_0000, "R8 load min");
      op(32'h0000_0001, 32'h0000_FFFF, 1'b1, 1'b0, "R3 word no sat borrow");
      // long mode saturation
      load(32'h1234_5678, 32'd0, "R8 load hi pattern");
      op(32'd2, 32'd3, 1'b0, 1'b1, "R4 long sat positive");
      load(32'h8000_1234, 32'd0, "R8 load hi negative");
      op(32'd1, 32'd1, 1'b0, 1'b1, "R4 long sat negative");
      load(32'd0, 32'd5, "R8 load small");
      op(32'hFFFF_FFFF, 32'd10, 1'b0, 1'b1, "R4 long sat crosses zero");
      // single-half loads with op offered
      drive(1'b1, 32'd7, 32'd7, 1'b0, 1'b0, 1'b0, 1'b1, 32'hAAAA_5555,
            1'b0, '0, "R8 hi-only load");
      drive(1'b1, 32'd7, 32'd7, 1'b1, 1'b0, 1'b0, 1'b0, '0,
            1'b1, 32'h0F0F_0F0F, "R8 lo-only load");
      // idle hold with changing operands
      drive(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'd1,
            1'b0, 32'd2, "R9 idle hold");
      drive(1'b0, 32'h1234_0000, 32'd77, 1'b1, 1'b0, 1'b0, 1'b0, '0,
            1'b0, '0, "R9 idle hold 2");
      op(32'd2, 32'd2, 1'b0, 1'b0, "R9 next-cycle result");
      drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, '0, "R7 plain clear");
      drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R9 idle after clear");

      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule